// File: doc/BRIEF.md
# Successive-Approximation Oscillator Tuner

This block finds the control code for a voltage-controlled oscillator so that the oscillator's measured period count matches a fixed target. It drives a DAC code and asks an external period-counting unit for a measurement at each trial code. It tells that unit how many oscillator cycles to time, which is 2^octave. Because the cycle count doubles with each octave, one reference count of 20000 serves every octave. Each code bit is decided by one measurement, working from the most-significant bit down. A returned count below the reference means the oscillator runs too fast. That is an overshoot, and the trial bit is dropped.

There are two ways to run it. In single mode one octave is tuned. In sweep mode octaves 0 to 8 are tuned in ascending order. Each converged code is stored per octave. It can be read back, together with its signed deviation from an ideal code (the bias), through a combinational read port. If the counting unit reports a timeout, the run stops with an error and the last code known to be good is left on the DAC.

FSM states: `ST_IDLE` (after reset), `ST_TRIAL` (put kept bits plus the trial bit on the DAC), `ST_REQ` (one-cycle measurement request), `ST_WAIT` (wait for done or timeout), `ST_EVAL` (keep or drop the trial bit, step down one bit), `ST_STORE` (record the octave's code and show it), `ST_DONE` (finished), `ST_FAULT` (timeout).

Transitions:
- IDLE, DONE and FAULT go to TRIAL on `start`.
- TRIAL goes to REQ, and REQ goes to WAIT.
- WAIT goes to FAULT on timeout, otherwise to EVAL on done.
- EVAL goes to TRIAL, or to STORE after bit 0.
- STORE goes to DONE after the last octave, otherwise to TRIAL for the next octave.

Top module: `sar_tune_ctrl`

## Requirements
- R1: The first measurement of every octave is taken with only DAC bit 13 set (code 0x2000).
- R2: A trial bit is kept when the returned count is greater than or equal to the reference 20000, and cleared otherwise. For a count that falls as the code rises, the result is the largest code whose count is at least 20000, or 0 if there is none.
- R3: While `meas_start` is high, `cycle_count` equals 2^octave, where octave is the one being tuned.
- R4: Each octave uses exactly 14 measurements. `meas_start` is a one-cycle pulse and is not raised again until that measurement has been answered.
- R5: Single mode (`sweep`=0) tunes `octave_sel`; a value above 8 is treated as 8. At the end, `done`=1, `busy`=0, and `dac_code` holds the converged code.
- R6: Sweep mode (`sweep`=1) tunes octaves 0 to 8 in ascending order. Each result can then be read as `rd_code` for `rd_octave`.
- R7: `rd_bias` is the signed 15-bit value `rd_code` − (1024 + 1638·`rd_octave`).
- R8: A timeout sets `error`, stops the run and puts the last kept code on `dac_code`. A timeout wins over a done flag raised in the same cycle.
- R9: `start` is ignored while `busy` is high. It is accepted in idle, done or error, and it clears `done` and `error`.
- R10: After reset, `dac_code`, `busy`, `done`, `error` and `meas_start` are 0, and every stored code reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run |
| sweep | input | 1 | 1: all octaves, 0: single octave |
| octave_sel | input | 4 | Octave for single mode |
| meas_start | output | 1 | Measurement request pulse |
| cycle_count | output | 9 | Oscillator cycles to time |
| meas_done | input | 1 | Measurement finished |
| meas_count | input | 16 | Measured period count |
| meas_timeout | input | 1 | Measurement failed |
| dac_code | output | 14 | DAC control code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished without error |
| error | output | 1 | Run aborted by timeout |
| rd_octave | input | 4 | Read-port octave |
| rd_code | output | 14 | Stored code for `rd_octave` |
| rd_bias | output | 15 | Signed deviation from the ideal code |

## Verification
A measurement completion and a measurement timeout can land in the same `ST_WAIT` cycle. The bench provokes this on purpose by raising `meas_done` and `meas_timeout` together partway through a search. It then expects the fault path: `error` high, `done` low, and `dac_code` equal to the code of the last measurement whose count met the reference. A second overlap also gets a directed case: a `start` that arrives while the block is busy. The bench judges it by the unchanged octave result and by the total of 14 requests.

// File: rtl/sar_tune_pkg.sv
package sar_tune_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRIAL,
        ST_REQ,
        ST_WAIT,
        ST_EVAL,
        ST_STORE,
        ST_DONE,
        ST_FAULT
    } tune_state_e;

endpackage

// File: rtl/sar_tune_table.sv
module sar_tune_table #(
    parameter int OCT_N     = 9,
    parameter int OCT_W     = 4,
    parameter int CNT_W     = 16,
    parameter int CYC_W     = 9,
    parameter int REF_COUNT = 20000
) (
    input  logic [OCT_W-1:0] oct,
    output logic [CNT_W-1:0] ref_count,
    output logic [CYC_W-1:0] cycle_count
);

    logic [CNT_W-1:0] ref_tab [OCT_N];
    logic [CYC_W-1:0] cyc_tab [OCT_N];

    // one row per octave: same target, doubled cycle count
    for (genvar g = 0; g < OCT_N; g++) begin : g_row
        assign ref_tab[g] = CNT_W'(REF_COUNT);
        assign cyc_tab[g] = CYC_W'(1) << g;
    end

    always_comb begin
        ref_count   = '0;
        cycle_count = '0;
        for (int i = 0; i < OCT_N; i++) begin
            if (oct == OCT_W'(i)) begin
                ref_count   = ref_tab[i];
                cycle_count = cyc_tab[i];
            end
        end
    end

endmodule

// File: rtl/sar_tune_bitreg.sv
module sar_tune_bitreg #(
    parameter int DAC_W = 14,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             apply,
    input  logic             evaluate,
    input  logic             keep,
    input  logic             restore,
    output logic [DAC_W-1:0] code_o,
    output logic [DAC_W-1:0] kept_o,
    output logic             last_bit_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DAC_W - 1);

    logic [DAC_W-1:0] code_q;
    logic [DAC_W-1:0] kept_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            kept_q <= '0;
            idx_q  <= TOP_IDX;
        end else begin
            if (clear) begin
                kept_q <= '0;
                idx_q  <= TOP_IDX;
            end else if (evaluate) begin
                if (keep) begin
                    kept_q <= code_q;
                end
                if (idx_q != '0) begin
                    idx_q <= idx_q - IDX_W'(1);
                end
            end
            if (apply) begin
                code_q <= kept_q | (DAC_W'(1) << idx_q);
            end else if (restore) begin
                code_q <= kept_q;
            end
        end
    end

    assign code_o     = code_q;
    assign kept_o     = kept_q;
    assign last_bit_o = (idx_q == '0);

    // R1: the first trial of a search carries the MSB alone
    p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && idx_q == TOP_IDX) |=> code_q == (DAC_W'(1) << (DAC_W - 1)));

    // R2: an overshooting trial leaves the kept bits untouched
    p_drop_overshoot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evaluate && !keep && !clear) |=> kept_q == $past(kept_q));

    // R2: a passing trial becomes the kept code
    p_keep_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evaluate && keep && !clear) |=> kept_q == $past(code_q));

endmodule

// File: rtl/sar_tune_store.sv
module sar_tune_store #(
    parameter int OCT_N      = 9,
    parameter int OCT_W      = 4,
    parameter int DAC_W      = 14,
    parameter int IDEAL_BASE = 1024,
    parameter int IDEAL_STEP = 1638
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OCT_W-1:0] wr_oct,
    input  logic [DAC_W-1:0] wr_code,
    input  logic [OCT_W-1:0] rd_oct,
    output logic [DAC_W-1:0] rd_code,
    output logic [DAC_W:0]   rd_bias
);

    logic [DAC_W-1:0] slot_q    [OCT_N];
    logic [DAC_W-1:0] ideal_tab [OCT_N];
    logic [DAC_W-1:0] ideal_rd;

    for (genvar g = 0; g < OCT_N; g++) begin : g_ideal
        assign ideal_tab[g] = DAC_W'(IDEAL_BASE + g * IDEAL_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < OCT_N; i++) begin
                slot_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < OCT_N; i++) begin
                if (wr_oct == OCT_W'(i)) begin
                    slot_q[i] <= wr_code;
                end
            end
        end
    end

    always_comb begin
        rd_code  = '0;
        ideal_rd = '0;
        for (int i = 0; i < OCT_N; i++) begin
            if (rd_oct == OCT_W'(i)) begin
                rd_code  = slot_q[i];
                ideal_rd = ideal_tab[i];
            end
        end
    end

    assign rd_bias = $signed({1'b0, rd_code}) - $signed({1'b0, ideal_rd});

endmodule

// File: rtl/sar_tune_ctrl.sv
module sar_tune_ctrl
    import sar_tune_pkg::*;
#(
    parameter int DAC_W      = 14,
    parameter int CNT_W      = 16,
    parameter int OCT_N      = 9,
    parameter int REF_COUNT  = 20000,
    parameter int IDEAL_BASE = 1024,
    parameter int IDEAL_STEP = 1638,
    parameter int OCT_W      = $clog2(OCT_N),
    parameter int CYC_W      = OCT_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sweep,
    input  logic [OCT_W-1:0] octave_sel,
    output logic             meas_start,
    output logic [CYC_W-1:0] cycle_count,
    input  logic             meas_done,
    input  logic [CNT_W-1:0] meas_count,
    input  logic             meas_timeout,
    output logic [DAC_W-1:0] dac_code,
    output logic             busy,
    output logic             done,
    output logic             error,
    input  logic [OCT_W-1:0] rd_octave,
    output logic [DAC_W-1:0] rd_code,
    output logic [DAC_W:0]   rd_bias
);

    localparam int               IDX_W   = $clog2(DAC_W);
    localparam logic [OCT_W-1:0] OCT_MAX = OCT_W'(OCT_N - 1);

    tune_state_e      state_q, state_d;
    logic [OCT_W-1:0] cur_oct_q, last_oct_q, sel_clamped;
    logic [CNT_W-1:0] cnt_q, ref_count;
    logic [DAC_W-1:0] kept_code;
    logic             last_bit, final_oct, accept_start;
    logic             do_clear, do_apply, do_eval, do_keep, do_restore, do_wr, do_latch;

    assign sel_clamped = (octave_sel > OCT_MAX) ? OCT_MAX : octave_sel;
    assign final_oct   = (cur_oct_q == last_oct_q);

    sar_tune_table #(
        .OCT_N(OCT_N), .OCT_W(OCT_W), .CNT_W(CNT_W),
        .CYC_W(CYC_W), .REF_COUNT(REF_COUNT)
    ) u_table (
        .oct         (cur_oct_q),
        .ref_count   (ref_count),
        .cycle_count (cycle_count)
    );

    sar_tune_bitreg #(
        .DAC_W(DAC_W), .IDX_W(IDX_W)
    ) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (do_clear),
        .apply      (do_apply),
        .evaluate   (do_eval),
        .keep       (do_keep),
        .restore    (do_restore),
        .code_o     (dac_code),
        .kept_o     (kept_code),
        .last_bit_o (last_bit)
    );

    sar_tune_store #(
        .OCT_N(OCT_N), .OCT_W(OCT_W), .DAC_W(DAC_W),
        .IDEAL_BASE(IDEAL_BASE), .IDEAL_STEP(IDEAL_STEP)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_wr),
        .wr_oct  (cur_oct_q),
        .wr_code (kept_code),
        .rd_oct  (rd_octave),
        .rd_code (rd_code),
        .rd_bias (rd_bias)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: if (start) state_d = ST_TRIAL;
            ST_TRIAL: state_d = ST_REQ;
            ST_REQ:   state_d = ST_WAIT;
            ST_WAIT: begin
                if (meas_timeout)   state_d = ST_FAULT;
                else if (meas_done) state_d = ST_EVAL;
            end
            ST_EVAL:  state_d = last_bit ? ST_STORE : ST_TRIAL;
            ST_STORE: state_d = final_oct ? ST_DONE : ST_TRIAL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_oct_q  <= '0;
            last_oct_q <= '0;
            cnt_q      <= '0;
        end else begin
            state_q <= state_d;
            if (accept_start) begin
                cur_oct_q  <= sweep ? '0 : sel_clamped;
                last_oct_q <= sweep ? OCT_MAX : sel_clamped;
            end else if (state_q == ST_STORE && !final_oct) begin
                cur_oct_q <= cur_oct_q + OCT_W'(1);
            end
            if (do_latch) begin
                cnt_q <= meas_count;
            end
        end
    end

    // outputs and strobes
    always_comb begin
        accept_start = 1'b0;
        meas_start   = 1'b0;
        busy         = 1'b1;
        done         = 1'b0;
        error        = 1'b0;
        do_apply     = 1'b0;
        do_eval      = 1'b0;
        do_restore   = 1'b0;
        do_wr        = 1'b0;
        do_latch     = 1'b0;
        do_keep      = (cnt_q >= ref_count);
        unique case (state_q)
            ST_IDLE: begin
                busy         = 1'b0;
                accept_start = start;
            end
            ST_DONE: begin
                busy         = 1'b0;
                done         = 1'b1;
                accept_start = start;
            end
            ST_FAULT: begin
                busy         = 1'b0;
                error        = 1'b1;
                accept_start = start;
            end
            ST_TRIAL: do_apply   = 1'b1;
            ST_REQ:   meas_start = 1'b1;
            ST_WAIT: begin
                do_restore = meas_timeout;
                do_latch   = meas_done && !meas_timeout;
            end
            ST_EVAL: do_eval = 1'b1;
            ST_STORE: begin
                do_wr      = 1'b1;
                do_restore = 1'b1;
            end
            default: busy = 1'b0;
        endcase
        do_clear = accept_start || (state_q == ST_STORE && !final_oct);
    end

    // R4: one-cycle request pulse
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |=> !meas_start);

    // R3: cycle count matches the octave under test
    p_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> cycle_count == (CYC_W'(1) << cur_oct_q));

    // R5: finished and busy never together
    p_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R8: the code stays put while parked in error
    p_hold_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> $stable(dac_code));

    // R9: a start seen while busy does not reload the octave
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_STORE) |=> $stable(cur_oct_q));

endmodule

// File: tb/sar_tune_ctrl_tb.sv
module sar_tune_ctrl_tb;

    localparam int REF   = 20000;
    localparam int DW    = 14;
    localparam int NOCT  = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sweep = 1'b0;
    logic [3:0]  octave_sel = '0;
    logic        meas_start;
    logic [8:0]  cycle_count;
    logic        meas_done = 1'b0;
    logic [15:0] meas_count = '0;
    logic        meas_timeout = 1'b0;
    logic [13:0] dac_code;
    logic        busy, done, error;
    logic [3:0]  rd_octave = '0;
    logic [13:0] rd_code;
    logic [14:0] rd_bias;

    int total = 0;
    int bad   = 0;
    int base [NOCT];
    int req_n;
    int first_oct;
    int kept_m;
    int to_at = -1;
    bit both_at = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sar_tune_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sweep(sweep),
        .octave_sel(octave_sel), .meas_start(meas_start),
        .cycle_count(cycle_count), .meas_done(meas_done),
        .meas_count(meas_count), .meas_timeout(meas_timeout),
        .dac_code(dac_code), .busy(busy), .done(done), .error(error),
        .rd_octave(rd_octave), .rd_code(rd_code), .rd_bias(rd_bias)
    );

    function automatic int model(int code, int oct);
        int v;
        v = base[oct] - (code >>> 1);
        if (v < 0) v = 0;
        if (v > 65535) v = 65535;
        return v;
    endfunction

    function automatic int expect_code(int oct);
        int best;
        best = 0;
        for (int c = 0; c < (1 << DW); c++) begin
            if (model(c, oct) >= REF) best = c;
        end
        return best;
    endfunction

    function automatic int ideal(int oct);
        return 1024 + 1638 * oct;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // measurement responder
    initial begin
        forever begin
            @(negedge clk);
            if (meas_start) begin
                int code_r, oct_e, cnt;
                code_r = int'(dac_code);
                oct_e  = first_oct + req_n / DW;
                if (req_n % DW == 0) begin
                    kept_m = 0;
                    check(code_r == (1 << (DW - 1)), "R1 first trial code", code_r, 1 << (DW - 1));
                end
                check(int'(cycle_count) == (1 << oct_e), "R3 cycle count", int'(cycle_count), 1 << oct_e);
                cnt = model(code_r, oct_e);
                repeat (1 + $urandom_range(0, 3)) @(negedge clk);
                check(!meas_start, "R4 no repeat request", int'(meas_start), 0);
                if (req_n == to_at) begin
                    meas_timeout = 1'b1;
                    if (both_at) begin
                        meas_done  = 1'b1;
                        meas_count = 16'(cnt);
                    end
                end else begin
                    meas_done  = 1'b1;
                    meas_count = 16'(cnt);
                    if (cnt >= REF) kept_m = code_r;
                end
                req_n++;
                @(negedge clk);
                meas_done    = 1'b0;
                meas_timeout = 1'b0;
            end
        end
    end

    task automatic run(input bit sw, input int sel, input int oct_first, input int stray_at);
        int n;
        req_n     = 0;
        kept_m    = 0;
        first_oct = oct_first;
        @(negedge clk);
        sweep      = sw;
        octave_sel = 4'(sel);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!(done || error) && n < 20000) begin
            @(negedge clk);
            n++;
            if (n == stray_at) begin
                sweep      = 1'b1;
                octave_sel = 4'd2;
                start      = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
    endtask

    task automatic check_single(input int oct, input string tag);
        int e;
        e = expect_code(oct);
        check(done && !busy && !error, "R5 done flags", {29'd0, done, busy, error}, 4);
        check(int'(dac_code) == e, "R2 converged code", int'(dac_code), e);
        check(req_n == DW, "R4 request count", req_n, DW);
        rd_octave = 4'(oct);
        #1;
        check(int'(rd_code) == e, "R5 stored code", int'(rd_code), e);
        check(int'($signed(rd_bias)) == e - ideal(oct), "R7 bias", int'($signed(rd_bias)), e - ideal(oct));
        if (tag.len() > 0) $display("  run %s oct=%0d code=%0d", tag, oct, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int o = 0; o < NOCT; o++) base[o] = 24000;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(dac_code == 0, "R10 reset dac", int'(dac_code), 0);
        check(!busy && !done && !error, "R10 reset flags", {29'd0, busy, done, error}, 0);
        check(!meas_start, "R10 reset request", int'(meas_start), 0);
        rst_n = 1'b1;
        for (int o = 0; o < NOCT; o++) begin
            rd_octave = 4'(o);
            #1;
            check(rd_code == 0, "R10 reset store", int'(rd_code), 0);
        end

        // random single-octave runs (R2, R5)
        for (int t = 0; t < 4; t++) begin
            int o;
            o = $urandom_range(0, NOCT - 1);
            base[o] = $urandom_range(19000, 29000);
            run(1'b0, o, o, -1);
            check_single(o, "");
        end

        // directed corners: never reaching the target, always above it (R2)
        base[3] = 15000;
        run(1'b0, 3, 3, -1);
        check_single(3, "");
        base[4] = 40000;
        run(1'b0, 4, 4, -1);
        check_single(4, "");
        check(dac_code == 14'h3fff, "R2 all ones", int'(dac_code), 16383);

        // clamp above octave 8 (R5)
        base[8] = $urandom_range(19000, 29000);
        run(1'b0, 12, 8, -1);
        check_single(8, "");

        // start while busy is ignored (R9)
        base[1] = $urandom_range(19000, 29000);
        run(1'b0, 1, 1, 20);
        check_single(1, "");

        // sweep all octaves (R6, R7)
        for (int o = 0; o < NOCT; o++) base[o] = $urandom_range(19000, 29000);
        run(1'b1, 0, 0, -1);
        check(done && !error, "R6 sweep done", int'(done), 1);
        check(req_n == DW * NOCT, "R6 sweep requests", req_n, DW * NOCT);
        check(int'(dac_code) == expect_code(NOCT - 1), "R6 final code", int'(dac_code), expect_code(NOCT - 1));
        for (int o = 0; o < NOCT; o++) begin
            rd_octave = 4'(o);
            #1;
            check(int'(rd_code) == expect_code(o), "R6 sweep store", int'(rd_code), expect_code(o));
            check(int'($signed(rd_bias)) == expect_code(o) - ideal(o), "R7 sweep bias",
                  int'($signed(rd_bias)), expect_code(o) - ideal(o));
        end

        // timeout mid-search (R8)
        base[5] = $urandom_range(19000, 29000);
        to_at = 6;
        run(1'b0, 5, 5, -1);
        check(error && !done && !busy, "R8 error flag", {29'd0, error, done, busy}, 4);
        check(int'(dac_code) == kept_m, "R8 last kept code", int'(dac_code), kept_m);
        repeat (3) @(negedge clk);
        check(int'(dac_code) == kept_m, "R8 code held", int'(dac_code), kept_m);

        // done and timeout in the same cycle (R8)
        base[2] = $urandom_range(19000, 29000);
        to_at = 9;
        both_at = 1'b1;
        run(1'b0, 2, 2, -1);
        check(error && !done, "R8 timeout wins", int'(error), 1);
        check(int'(dac_code) == kept_m, "R8 kept on tie", int'(dac_code), kept_m);

        // restart from error clears it (R9)
        to_at = -1;
        both_at = 1'b0;
        run(1'b0, 2, 2, -1);
        check(!error, "R9 error cleared", int'(error), 0);
        check_single(2, "");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule